// File: doc/BRIEF.md
# Three-Phase Synchronous Serial Transmitter

This block drives a two-wire synchronous link made of a DATA line and a CLOCK line. Its input is a phase tick that runs at three times the wanted bit rate. The block splits each bit period into three tick phases. In the first phase it puts the bit on DATA. In the second phase it drives CLOCK active. In the third phase it drives CLOCK inactive again. A receiver therefore gets one phase of setup time before it samples on the active CLOCK edge.

A transfer begins with a start pulse. The block then reads bytes one at a time from a buffer interface, using a single-cycle request strobe and a ready/data answer. It shifts each byte out least-significant bit first. Characters follow each other with no gap. A fetched byte of zero is not transmitted: it ends the transfer and clears busy. One polarity input inverts both lines, which lets the block drive an inverting line buffer. The baud tick and the filling of the buffer belong to the surrounding logic.

Top module: `sync3_serial_tx`

## Requirements
- R1: After reset, and whenever busy is low, DATA and CLOCK rest at their inactive levels (low when invert is 0), busy is 0 and the byte request is 0.
- R2: A start pulse while idle raises busy, and the first byte request appears within one tick period plus one cycle.
- R3: Each bit occupies exactly three ticks. CLOCK stays active for exactly one tick period, and consecutive active CLOCK edges within a transfer are three ticks apart.
- R4: DATA never changes while CLOCK is active.
- R5: Each byte is sent as eight bits, least significant first, and the first bit of the next byte follows the last bit of the previous byte with no idle ticks.
- R6: A fetched byte equal to 0x00 ends the transfer. No CLOCK pulse is produced for it, and busy returns to 0. A zero as the first byte gives a transfer with no pulses.
- R7: When invert is 1, both DATA and CLOCK are inverted, including their idle levels (both high when idle).
- R8: A start pulse that arrives while busy is ignored. It neither restarts nor lengthens the transfer.
- R9: The byte request is high for exactly one cycle per fetch. The byte is taken only in a cycle when ready is high. While ready is low the block waits with CLOCK inactive and busy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse that begins a transfer when idle |
| tick_i | input | 1 | Phase tick, three per bit |
| byte_i | input | BYTE_W | Byte from the buffer |
| byte_ready_i | input | 1 | byte_i is valid and may be taken |
| invert_i | input | 1 | Invert polarity of DATA and CLOCK |
| data_o | output | 1 | Serial DATA line |
| clock_o | output | 1 | Serial CLOCK line |
| busy_o | output | 1 | Transfer in progress |
| byte_req_o | output | 1 | One-cycle request for the next byte |

## Verification
The bench decodes the DATA/CLOCK pair the way a receiver would. It checks that bytes arrive LSB first. It also checks that pulse width and pulse spacing stay fixed across byte boundaries. An off-by-one bit counter would show up as a lost or extra bit. A fetch that added a tick would show up as a wider gap at character edges. The bench sends a zero in the middle of a message and as the first byte. A design that sent the terminator, or that stopped on a fixed count, would produce extra pulses. It stalls ready after the first request and fires a second start during a transfer. A design that took stale data, pulsed CLOCK while waiting, or restarted on the second start would fail the request count or the decoded bytes.

// File: rtl/sync3_tx_pkg.sv
package sync3_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_SEND} tx_state_e;
  typedef enum logic [1:0] {PH_SETUP, PH_HIGH, PH_LOW} tx_phase_e;
endpackage

// File: rtl/sync3_tx_shifter.sv
module sync3_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load_i) begin
      sr_d  = byte_i;
      cnt_d = CNT_TOP;
    end else if (shift_i) begin
      sr_d  = sr_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i || shift_i) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (cnt_q == '0);

  // R5: the controller never loads and shifts at once, and never shifts past the last bit
  p_load_shift_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));
  p_no_overshift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (cnt_q != '0));
endmodule

// File: rtl/sync3_tx_ctrl.sv
module sync3_tx_ctrl
  import sync3_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic ready_i,
  input  logic zero_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic req_o,
  output logic busy_o,
  output logic send_o,
  output logic clk_o
);
  tx_state_e st_q, st_d;
  tx_phase_e ph_q, ph_d;
  logic      clk_q, clk_d;
  logic      req_q, fetch;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    clk_d   = clk_q;
    fetch   = 1'b0;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_REQ;
          ph_d = PH_LOW;
        end
      end
      ST_REQ: begin
        if (tick_i) begin
          fetch = 1'b1;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ready_i) begin
          if (zero_i) begin
            st_d = ST_IDLE;
          end else begin
            load_o = 1'b1;
            st_d   = ST_SEND;
            ph_d   = PH_SETUP;
          end
        end
      end
      ST_SEND: begin
        if (tick_i) begin
          unique case (ph_q)
            PH_SETUP: begin
              clk_d = 1'b1;
              ph_d  = PH_HIGH;
            end
            PH_HIGH: begin
              clk_d = 1'b0;
              ph_d  = PH_LOW;
            end
            default: begin
              if (last_i) begin
                fetch = 1'b1;
                st_d  = ST_WAIT;
              end else begin
                shift_o = 1'b1;
                ph_d    = PH_SETUP;
              end
            end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_LOW;
      clk_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      clk_q <= clk_d;
      req_q <= fetch;
    end
  end

  assign req_o  = req_q;
  assign busy_o = (st_q != ST_IDLE);
  assign send_o = (st_q == ST_SEND);
  assign clk_o  = clk_q;

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  p_wait_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !ready_i) |=> (st_q == ST_WAIT && !clk_q));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!clk_q && !req_q));
  p_clk_only_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> (st_q == ST_SEND));
  p_clk_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && !tick_i) |=> clk_q);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && start_i) |=> (st_q != ST_REQ));
endmodule

// File: rtl/sync3_serial_tx.sv
module sync3_serial_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_ready_i,
  input  logic              invert_i,
  output logic              data_o,
  output logic              clock_o,
  output logic              busy_o,
  output logic              byte_req_o
);
  logic load, shift, last, bit_val, send, clk_raw, data_raw, zero;

  assign zero = (byte_i == '0);

  sync3_tx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick_i),
    .ready_i (byte_ready_i),
    .zero_i  (zero),
    .last_i  (last),
    .load_o  (load),
    .shift_o (shift),
    .req_o   (byte_req_o),
    .busy_o  (busy_o),
    .send_o  (send),
    .clk_o   (clk_raw)
  );

  sync3_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .shift_i (shift),
    .byte_i  (byte_i),
    .bit_o   (bit_val),
    .last_o  (last)
  );

  assign data_raw = send & bit_val;
  assign data_o   = data_raw ^ invert_i;
  assign clock_o  = clk_raw ^ invert_i;

  p_idle_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (data_o == invert_i && clock_o == invert_i));
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_raw && $past(clk_raw)) |-> $stable(data_raw));
endmodule

// File: tb/tb_sync3_serial_tx.sv
module tb_sync3_serial_tx;
  localparam int TD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic [7:0] byte_i;
  logic byte_ready_i = 1'b1;
  logic invert_i = 1'b0;
  logic data_o, clock_o, busy_o, byte_req_o;

  always #2 clk = ~clk;

  sync3_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .byte_i(byte_i), .byte_ready_i(byte_ready_i), .invert_i(invert_i),
    .data_o(data_o), .clock_o(clock_o), .busy_o(busy_o), .byte_req_o(byte_req_o)
  );

  // {invert, expected byte count, bytes (first byte in [7:0])}; a zero follows the 4 bytes
  localparam logic [35:0] VEC [6] = '{
    36'h4_5AC30F41, 36'hC_8001FFAA, 36'h2_33007E81,
    36'h9_00000055, 36'h0_12345600, 36'h3_000102FE };

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [0:7];
  int idx = 0;
  logic pend = 1'b0;

  assign byte_i = mem[idx];

  // buffer model: consume a byte on an edge where the design can take it
  always @(posedge clk) begin
    if (byte_req_o) pend <= 1'b1;
    if ((pend || byte_req_o) && byte_ready_i) begin
      idx  <= idx + 1;
      pend <= 1'b0;
    end
  end

  int tcnt = 0;
  always begin
    @(posedge clk); #1;
    tcnt = (tcnt == TD - 1) ? 0 : tcnt + 1;
    tick_i = (tcnt == 0);
  end

  // receiver-side monitor
  int cyc = 0, rises = 0, last_rise = 0, hi_len = 0, nb = 0, rx_n = 0;
  int gap_err = 0, wid_err = 0, chg_err = 0, req_cnt = 0, req_dbl = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx [0:7];
  logic pc = 1'b0, pd = 1'b0, pr = 1'b0;
  always @(negedge clk) begin
    logic lc, ld;
    cyc++;
    lc = clock_o ^ invert_i;
    ld = data_o ^ invert_i;
    if (lc && !pc) begin
      if (rises > 0 && (cyc - last_rise) != 3 * TD) gap_err++;
      last_rise = cyc;
      rises++;
      sh = {ld, sh[7:1]};
      nb++;
      if (nb == 8) begin
        if (rx_n < 8) rx[rx_n] = sh;
        rx_n++;
        nb = 0;
      end
      hi_len = 1;
    end else if (lc && pc) begin
      hi_len++;
      if (ld != pd) chg_err++;
    end
    if (!lc && pc && hi_len != TD) wid_err++;
    if (byte_req_o) begin
      req_cnt++;
      if (pr) req_dbl++;
    end
    pc = lc; pd = ld; pr = byte_req_o;
  end

  task automatic clr_mon();
    rises = 0; nb = 0; rx_n = 0; gap_err = 0; wid_err = 0; chg_err = 0;
    req_cnt = 0; req_dbl = 0;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (busy_o && n < 4000) begin
      @(negedge clk); n++;
    end
    chk(n < 4000, "R6 busy clears", n, 4000);
    repeat (4) @(negedge clk);
  endtask

  task automatic load_msg(input logic [31:0] b);
    for (int k = 0; k < 4; k++) mem[k] = b[8*k +: 8];
    for (int k = 4; k < 8; k++) mem[k] = 8'h00;
    idx = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    load_msg(32'h0);
    repeat (3) @(negedge clk);
    chk(!busy_o && !data_o && !clock_o && !byte_req_o, "R1 reset levels",
        {busy_o, data_o, clock_o, byte_req_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !data_o && !clock_o, "R1 idle after reset", {busy_o, data_o, clock_o}, 0);

    for (int v = 0; v < 6; v++) begin
      int cnt;
      cnt = int'(VEC[v][34:32]);
      @(posedge clk); #1 invert_i = VEC[v][35];
      load_msg(VEC[v][31:0]);
      repeat (2) @(negedge clk);
      chk(data_o == invert_i && clock_o == invert_i, "R7 idle polarity",
          {data_o, clock_o}, {invert_i, invert_i});
      clr_mon();
      pulse_start();
      chk(busy_o || cnt == 0, "R2 busy after start", busy_o, 1);
      repeat (TD + 2) @(negedge clk);
      chk(req_cnt >= 1, "R2 first request", req_cnt, 1);
      wait_done();
      chk(rx_n == cnt && nb == 0, "R6 byte count", rx_n, cnt);
      for (int k = 0; k < cnt; k++)
        chk(rx[k] == VEC[v][8*k +: 8], "R5 byte value", rx[k], VEC[v][8*k +: 8]);
      chk(gap_err == 0, "R3 R5 pulse spacing", gap_err, 0);
      chk(wid_err == 0, "R3 pulse width", wid_err, 0);
      chk(chg_err == 0, "R4 data stable", chg_err, 0);
      chk(req_cnt == cnt + 1 && req_dbl == 0, "R9 request pulses", req_cnt, cnt + 1);
      chk(data_o == invert_i && clock_o == invert_i, "R7 R1 rest after transfer",
          {data_o, clock_o}, {invert_i, invert_i});
    end

    // R9: stall ready before first byte
    @(posedge clk); #1 invert_i = 1'b0; byte_ready_i = 1'b0;
    load_msg(32'h0000_C6_39);
    clr_mon();
    pulse_start();
    while (req_cnt == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(rises == 0 && busy_o && !clock_o, "R9 stall holds", rises, 0);
    chk(req_cnt == 1, "R9 single request while stalled", req_cnt, 1);
    @(posedge clk); #1 byte_ready_i = 1'b1;
    wait_done();
    chk(rx_n == 2 && rx[0] == 8'h39 && rx[1] == 8'hC6, "R9 bytes after stall", rx[0], 8'h39);

    // R8: start while busy
    load_msg(32'h0000_A5_3C);
    clr_mon();
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done();
    chk(rx_n == 2 && rx[0] == 8'h3C && rx[1] == 8'hA5, "R8 transfer unchanged", rx_n, 2);
    chk(req_cnt == 3, "R8 no extra fetch", req_cnt, 3);
    repeat (30) @(negedge clk);
    chk(!busy_o && rises == 16, "R8 no restart", rises, 16);

    // R1: reset during a transfer
    load_msg(32'hFFFF_FFFF);
    clr_mon();
    pulse_start();
    repeat (40) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !clock_o && !data_o && !byte_req_o, "R1 reset mid-transfer",
        {busy_o, clock_o, data_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule